// File: doc/BRIEF.md
# Byte-Lane Carryless Multiplier

This block forms the full 128-bit carryless product of two 64-bit operands, as a polynomial product over GF(2). It has no 64-bit multiplier array. It builds the product only from 8x8-bit carryless lane multipliers. One set of lanes pairs equal byte positions. The other sets pair each byte of one operand with a byte-rotated copy of the other. Each rotated product lands at its true weight through a per-lane mask and two shifts. It serves as the polynomial multiply kernel wherever only byte-wide carryless multipliers fit the datapath.

A caller presents both operands with a one-cycle start strobe. The result appears two clock edges later with a one-cycle done strobe. A new start may be given on every cycle, so the block runs as a fully pipelined unit with a fixed latency.

Top module: `byte_clmul`

## Requirements
- R1: On each done pulse, `productO` bit k equals the coefficient of x^k in the carryless product of the operands that came with the matching start. Bit 0 of `aI` and of `bI` is the x^0 coefficient.
- R2: `productO[127]` is 0 on every done pulse.
- R3: `doneO` is high for one cycle exactly two rising edges after the edge that samples `startI` high. It pulses exactly once per start and never without one.
- R4: Starts on consecutive cycles are all accepted, and their results come out in issue order, one per cycle.
- R5: `productO` keeps its value on every cycle in which `doneO` is low.
- R6: While `rstN` is low, `doneO` is 0 and `productO` is all zeros.
- R7: If either operand is zero, the product is zero.
- R8: If either operand equals 1, the product equals the other operand zero-extended to 128 bits.
- R9: Single-term operands x^i and x^j give exactly bit i+j set. This holds for every byte pairing, including pairs where the rotated lane wraps past the top byte (for example x^63·x^63 gives bit 126, and x^7·x^56 gives bit 63).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkI | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| startI | input | 1 | Starts a product with the current operands |
| aI | input | 64 | First operand, bit 0 is x^0 |
| bI | input | 64 | Second operand, bit 0 is x^0 |
| doneO | output | 1 | One-cycle strobe: `productO` holds a new result |
| productO | output | 128 | Carryless product, bit k is x^k |

## Verification
The hardest case to reach from the ports is a wrapped lane. These are byte pairs whose rotated index passes the top byte, so that part of a rotated product must move down rather than up. Random operands mix those terms with many others, so an error in one wrapped lane can hide behind the rest. The stimulus therefore sweeps single-term operands x^i and x^j over every byte pairing, which isolates each lane's placement. All-ones and top-bit operands then load every wrapped lane at once. Long runs of starts on consecutive cycles, compared in order against a shift-and-XOR model, cover throughput and latency.

// File: rtl/byte_clmul_pkg.sv
`timescale 1ns/1ps
package byte_clmul_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic fire1;  // capture lane products
    logic fire2;  // capture merged product
  } stepCtrl_t;

  // 8x8 carryless lane product
  function automatic logic [15:0] clmul8(input logic [7:0] x, input logic [7:0] y);
    logic [15:0] acc;
    acc = '0;
    for (int i = 0; i < 8; i++) begin
      if (y[i]) acc = acc ^ ({8'b0, x} << i);
    end
    return acc;
  endfunction

endpackage

// File: rtl/byte_clmul_ctrl.sv
`timescale 1ns/1ps
module byte_clmul_ctrl
  import byte_clmul_pkg::*;
(
  input  logic      clkI,
  input  logic      rstN,
  input  logic      startI,
  output stepCtrl_t ctrlO,
  output logic      doneO
);

  logic stage1Valid;
  logic stage2Valid;

  always_ff @(posedge clkI or negedge rstN) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      stage2Valid <= 1'b0;
    end else begin
      stage1Valid <= startI;
      stage2Valid <= stage1Valid;
    end
  end

  always_comb begin
    ctrlO.fire1 = startI;
    ctrlO.fire2 = stage1Valid;
  end

  assign doneO = stage2Valid;

endmodule

// File: rtl/byte_clmul_dp.sv
`timescale 1ns/1ps
module byte_clmul_dp
  import byte_clmul_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                 clkI,
  input  logic                 rstN,
  input  stepCtrl_t            ctrlI,
  input  logic [8*LANES-1:0]   aI,
  input  logic [8*LANES-1:0]   bI,
  output logic [16*LANES-1:0]  productO
);

  localparam int OP_W   = 8 * LANES;
  localparam int PROD_W = 2 * OP_W;
  localparam int HALF   = LANES / 2;
  localparam int NSUM   = HALF + 1;  // distance 0 .. HALF

  // Lane sums per byte distance k, lane i at bits 16i
  logic [NSUM-1:0][PROD_W-1:0] sumD;
  logic [NSUM-1:0][PROD_W-1:0] sumQ;
  logic [PROD_W-1:0]           mergeD;

  for (genvar k = 0; k < NSUM; k++) begin : g_dist
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int PI = (i + k) % LANES;
      logic [15:0] lanePart;
      if (k == 0) begin : g_direct
        assign lanePart = clmul8(aI[8*i +: 8], bI[8*i +: 8]);
      end else if (k == HALF) begin : g_half
        // one rotation covers both signs of this distance
        assign lanePart = clmul8(aI[8*i +: 8], bI[8*PI +: 8]);
      end else begin : g_pair
        assign lanePart = clmul8(aI[8*PI +: 8], bI[8*i +: 8])
                        ^ clmul8(aI[8*i +: 8], bI[8*PI +: 8]);
      end
      assign sumD[k][16*i +: 16] = lanePart;
    end
  end

  always_ff @(posedge clkI or negedge rstN) begin
    if (!rstN)            sumQ <= '0;
    else if (ctrlI.fire1) sumQ <= sumD;
  end

  // Unwrapped lanes move up by k bytes, wrapped lanes move down by (LANES-k) bytes
  always_comb begin
    logic [PROD_W-1:0] keepMask;
    mergeD = '0;
    for (int k = 0; k < NSUM; k++) begin
      keepMask = '0;
      for (int i = 0; i < LANES - k; i++) keepMask[16*i +: 16] = '1;
      mergeD = mergeD
             ^ ((sumQ[k] & keepMask) << (8*k))
             ^ ((sumQ[k] & ~keepMask) >> (OP_W - 8*k));
    end
  end

  always_ff @(posedge clkI or negedge rstN) begin
    if (!rstN)            productO <= '0;
    else if (ctrlI.fire2) productO <= mergeD;
  end

endmodule

// File: rtl/byte_clmul.sv
`timescale 1ns/1ps
module byte_clmul
  import byte_clmul_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                clkI,
  input  logic                rstN,
  input  logic                startI,
  input  logic [8*LANES-1:0]  aI,
  input  logic [8*LANES-1:0]  bI,
  output logic                doneO,
  output logic [16*LANES-1:0] productO
);

  stepCtrl_t stepCtrl;

  byte_clmul_ctrl i_ctrl (
    .clkI   (clkI),
    .rstN   (rstN),
    .startI (startI),
    .ctrlO  (stepCtrl),
    .doneO  (doneO)
  );

  byte_clmul_dp #(.LANES(LANES)) i_dp (
    .clkI     (clkI),
    .rstN     (rstN),
    .ctrlI    (stepCtrl),
    .aI       (aI),
    .bI       (bI),
    .productO (productO)
  );

endmodule

// File: rtl/byte_clmul_chk.sv
`timescale 1ns/1ps
module byte_clmul_chk #(
  parameter int LANES = 8
) (
  input logic                clkI,
  input logic                rstN,
  input logic                startI,
  input logic [8*LANES-1:0]  aI,
  input logic [8*LANES-1:0]  bI,
  input logic                doneO,
  input logic [16*LANES-1:0] productO
);

  p_latency_r3: assert property (@(posedge clkI) disable iff (!rstN)
    startI |-> ##2 doneO);

  p_done_source_r3: assert property (@(posedge clkI) disable iff (!rstN)
    doneO |-> $past(startI, 2));

  p_top_bit_r2: assert property (@(posedge clkI) disable iff (!rstN)
    doneO |-> !productO[16*LANES-1]);

  p_hold_r5: assert property (@(posedge clkI) disable iff (!rstN)
    !doneO |-> $stable(productO));

  p_zero_operand_r7: assert property (@(posedge clkI) disable iff (!rstN)
    (doneO && ($past(aI, 2) == '0 || $past(bI, 2) == '0)) |-> productO == '0);

  p_reset_r6: assert property (@(posedge clkI)
    !rstN |=> (!doneO && productO == '0));

endmodule

bind byte_clmul byte_clmul_chk #(.LANES(LANES)) i_chk (.*);

// File: tb/test_byte_clmul.sv
`timescale 1ns/1ps
module test_byte_clmul;

  logic         clkI = 1'b0;
  logic         rstN = 1'b0;
  logic         startI = 1'b0;
  logic [63:0]  aI = '0;
  logic [63:0]  bI = '0;
  logic         doneO;
  logic [127:0] productO;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [127:0] expQ[$];
  int           issueQ[$];
  string        tagQ[$];
  logic [127:0] lastProd = '0;

  always #2 clkI = ~clkI;  // 250 MHz
  always @(posedge clkI) cyc <= cyc + 1;

  byte_clmul i_byte_clmul (.*);

  function automatic logic [127:0] refMul(input logic [63:0] a, input logic [63:0] b);
    logic [127:0] r;
    r = '0;
    for (int i = 0; i < 64; i++) if (b[i]) r = r ^ ({64'b0, a} << i);
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] a, input logic [63:0] b, input string tag);
    @(negedge clkI);
    startI = 1'b1;
    aI = a;
    bI = b;
    expQ.push_back(refMul(a, b));
    issueQ.push_back(cyc);
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clkI);
      startI = 1'b0;
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clkI) begin
    if (rstN && !finished) begin
      if (doneO) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3 spurious done", productO, '0);
        end else begin
          logic [127:0] e;
          int           iss;
          string        t;
          e = expQ.pop_front();
          iss = issueQ.pop_front();
          t = tagQ.pop_front();
          check(productO === e, t, productO, e);
          check(!productO[127], "R2 top bit", productO, e);
          check(cyc == iss + 2, "R3 latency", 128'(cyc), 128'(iss + 2));
        end
        lastProd = productO;
      end else begin
        check(productO === lastProd, "R5 hold", productO, lastProd);
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] r;
    repeat (3) @(negedge clkI);
    check(doneO === 1'b0, "R6 done in reset", 128'(doneO), '0);
    check(productO === '0, "R6 product in reset", productO, '0);
    rstN = 1'b1;
    idle(2);

    // R7 zero operand
    r = {$urandom, $urandom};
    drive('0, r, "R7 zero a");
    drive(r, '0, "R7 zero b");
    idle(4);
    // R8 identity
    r = {$urandom, $urandom};
    drive(64'd1, r, "R8 one a");
    drive(r, 64'd1, "R8 one b");
    idle(4);
    // R1/R2 all ones and top bits
    drive('1, '1, "R1 all ones");
    idle(3);
    drive(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R9 x63*x63");
    drive(64'h80, 64'h0100_0000_0000_0000, "R9 x7*x56");
    idle(3);
    // R9 single-term sweep across all byte pairings
    for (int i = 0; i < 64; i += 7) begin
      for (int j = 0; j < 64; j += 5) begin
        drive(64'd1 << i, 64'd1 << j, "R9 single term");
      end
    end
    drive(64'd1 << 63, 64'd1 << 56, "R9 wrap top");
    idle(4);
    // R4 back-to-back random
    for (int n = 0; n < 300; n++) drive({$urandom, $urandom}, {$urandom, $urandom}, "R4 back-to-back");
    idle(3);
    // R1 random with gaps
    for (int n = 0; n < 100; n++) begin
      drive({$urandom, $urandom}, {$urandom, $urandom}, "R1 random");
      idle(n % 3);
    end
    idle(6);
    check(expQ.size() == 0, "R3 missing done", 128'(expQ.size()), '0);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule